// File: doc/BRIEF.md
# Mode-Configurable Shared RAM Arbiter

This block places one single-ported RAM between a host processor and a coprocessor and, each cycle, lets at most one request reach the RAM port. The host side carries seven request classes, each with its own request bit, address and write data: instruction fetch, program read, program write, data read, data write, debug read and debug write. The coprocessor side carries a data read and a data write. It has no fetch class, so coprocessor fetches can never reach this RAM.

Two configuration inputs select one of three modes. With `cfg_map_cop` low, the RAM belongs to the host. With `cfg_map_cop` high, it belongs to the coprocessor, and `cfg_host_en` decides whether host data traffic is allowed alongside debug traffic. A request class that the active mode forbids is gated rather than faulted. A gated read answers zero on the next cycle, and a gated write is discarded. Neither one uses the RAM port or stalls. A permitted request that loses arbitration sees its stall output high until it wins. While it is stalled it must hold its request, address and data stable.

Top module: `shared_ram_arbiter`

## Requirements
- R1: With `cfg_map_cop`=0, every host class is permitted, and the winner is the first requester in this order: debug write, data write, program write, debug read, data read, fetch, program read. Host class indices on the packed ports are fetch=0, program read=1, program write=2, data read=3, data write=4, debug read=5, debug write=6.
- R2: With `cfg_map_cop`=1 and `cfg_host_en`=0, only debug reads and writes are permitted among the host classes. The order is coprocessor write, debug write, debug read, coprocessor read.
- R3: In the mode of R2, host fetch, program read and data read answer zero. Host program and data writes leave the RAM unchanged.
- R4: With both configuration bits at 1, host data reads and writes are also permitted. The order is coprocessor write, debug write, data write, debug read, data read, coprocessor read.
- R5: In the mode of R4, host fetch and program read answer zero, and host program writes leave the RAM unchanged.
- R6: With `cfg_map_cop`=0, a coprocessor read answers zero and a coprocessor write leaves the RAM unchanged.
- R7: A gated request never raises its stall output. A gated read pulses its valid exactly one cycle after it is presented.
- R8: A permitted request that is not granted has its stall output high in that same cycle, and in every later cycle until it is granted. A stall is high only while some other request holds the grant.
- R9: A granted read returns the RAM word one cycle after the grant, with a one-cycle valid pulse on that port only. Write classes never pulse valid.
- R10: At most one request reaches the RAM per cycle. A write granted in one cycle is visible to a read granted in the next cycle.
- R11: While `rst_n` is low, every read-valid output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_map_cop | input | 1 | 1 maps the RAM to the coprocessor |
| cfg_host_en | input | 1 | 1 allows host data access while mapped to the coprocessor |
| cpu_req | input | 7 | Host request, one bit per class |
| cpu_addr | input | 7*ADDR_W | Host word address, one field per class |
| cpu_wdata | input | 7*DATA_W | Host write data, one field per class (write classes only) |
| cpu_stall | output | 7 | Host stall, one bit per class |
| cpu_rvalid | output | 7 | Host read-data valid, one bit per class |
| cpu_rdata | output | 7*DATA_W | Host read data, one field per class |
| cop_rd_req | input | 1 | Coprocessor read request |
| cop_rd_addr | input | ADDR_W | Coprocessor read address |
| cop_wr_req | input | 1 | Coprocessor write request |
| cop_wr_addr | input | ADDR_W | Coprocessor write address |
| cop_wdata | input | DATA_W | Coprocessor write data |
| cop_rd_stall | output | 1 | Coprocessor read stall |
| cop_wr_stall | output | 1 | Coprocessor write stall |
| cop_rvalid | output | 1 | Coprocessor read-data valid |
| cop_rdata | output | DATA_W | Coprocessor read data |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=16. The sixteen-word RAM is small enough to fill completely before any read, so every later read has a known expected word, and random addresses often collide on the same word. This exposes write-then-read ordering across cycles and lost or stray writes from gated classes. The sixteen-bit data keeps a returned zero clearly distinct from the stored patterns.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;

  localparam int NCPU  = 7;
  localparam int NREQ  = 9;
  localparam int POS_W = 4;

  // unified requester indices
  localparam int IDX_FETCH  = 0;
  localparam int IDX_PRD    = 1;
  localparam int IDX_PWR    = 2;
  localparam int IDX_DRD    = 3;
  localparam int IDX_DWR    = 4;
  localparam int IDX_DBGRD  = 5;
  localparam int IDX_DBGWR  = 6;
  localparam int IDX_COP_RD = 7;
  localparam int IDX_COP_WR = 8;

  localparam logic [NREQ-1:0] RD_MASK = 9'b0_1010_1011;
  localparam logic [NREQ-1:0] WR_MASK = 9'b1_0101_0100;

  localparam logic [POS_W-1:0] POS_GATED = '1;

  typedef enum logic [1:0] {
    MODE_HOST    = 2'd0,
    MODE_COP_DBG = 2'd1,
    MODE_COP_SHR = 2'd2
  } mode_e;

  function automatic mode_e mode_of(input logic map_cop, input logic host_en);
    if (!map_cop)    return MODE_HOST;
    else if (host_en) return MODE_COP_SHR;
    else              return MODE_COP_DBG;
  endfunction

endpackage

// File: rtl/sram_arb_decode.sv
module sram_arb_decode
  import sram_arb_pkg::*;
(
  input  logic                        cfg_map_cop,
  input  logic                        cfg_host_en,
  output logic [NREQ-1:0][POS_W-1:0]  pos,
  output logic [NREQ-1:0]             legal
);

  mode_e mode;

  assign mode = mode_of(cfg_map_cop, cfg_host_en);

  // position 0 is the strongest; gated classes get POS_GATED
  always_comb begin
    for (int i = 0; i < NREQ; i++) pos[i] = POS_GATED;
    unique case (mode)
      MODE_HOST: begin
        pos[IDX_DBGWR] = 4'd0;
        pos[IDX_DWR]   = 4'd1;
        pos[IDX_PWR]   = 4'd2;
        pos[IDX_DBGRD] = 4'd3;
        pos[IDX_DRD]   = 4'd4;
        pos[IDX_FETCH] = 4'd5;
        pos[IDX_PRD]   = 4'd6;
      end
      MODE_COP_DBG: begin
        pos[IDX_COP_WR] = 4'd0;
        pos[IDX_DBGWR]  = 4'd1;
        pos[IDX_DBGRD]  = 4'd2;
        pos[IDX_COP_RD] = 4'd3;
      end
      MODE_COP_SHR: begin
        pos[IDX_COP_WR] = 4'd0;
        pos[IDX_DBGWR]  = 4'd1;
        pos[IDX_DWR]    = 4'd2;
        pos[IDX_DBGRD]  = 4'd3;
        pos[IDX_DRD]    = 4'd4;
        pos[IDX_COP_RD] = 4'd5;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_legal
    assign legal[g] = (pos[g] != POS_GATED);
  end

endmodule

// File: rtl/sram_arb_pick.sv
module sram_arb_pick #(
  parameter int N     = 9,
  parameter int POS_W = 4
) (
  input  logic [N-1:0]             elig,
  input  logic [N-1:0][POS_W-1:0]  pos,
  output logic [N-1:0]             grant
);

  logic [N-1:0] beaten;

  // a requester loses to any eligible requester with a smaller position
  always_comb begin
    for (int i = 0; i < N; i++) begin
      beaten[i] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && elig[j] && (pos[j] < pos[i])) beaten[i] = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_grant
    assign grant[g] = elig[g] & ~beaten[g];
  end

endmodule

// File: rtl/sram_arb_mem.sv
module sram_arb_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;

  // R10
  single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));

endmodule

// File: rtl/shared_ram_arbiter.sv
module shared_ram_arbiter
  import sram_arb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_map_cop,
  input  logic                     cfg_host_en,
  input  logic [6:0]               cpu_req,
  input  logic [7*ADDR_W-1:0]      cpu_addr,
  input  logic [7*DATA_W-1:0]      cpu_wdata,
  output logic [6:0]               cpu_stall,
  output logic [6:0]               cpu_rvalid,
  output logic [7*DATA_W-1:0]      cpu_rdata,
  input  logic                     cop_rd_req,
  input  logic [ADDR_W-1:0]        cop_rd_addr,
  input  logic                     cop_wr_req,
  input  logic [ADDR_W-1:0]        cop_wr_addr,
  input  logic [DATA_W-1:0]        cop_wdata,
  output logic                     cop_rd_stall,
  output logic                     cop_wr_stall,
  output logic                     cop_rvalid,
  output logic [DATA_W-1:0]        cop_rdata
);

  logic [NREQ-1:0]                req_all;
  logic [NREQ-1:0][ADDR_W-1:0]    addr_all;
  logic [NREQ-1:0][DATA_W-1:0]    wdata_all;
  logic [NREQ-1:0][POS_W-1:0]     pos;
  logic [NREQ-1:0]                legal;
  logic [NREQ-1:0]                elig;
  logic [NREQ-1:0]                grant;
  logic [NREQ-1:0]                stall_all;
  logic [NREQ-1:0]                rsp_ram_d, rsp_ram_q;
  logic [NREQ-1:0]                rsp_zero_d, rsp_zero_q;
  logic [NREQ-1:0]                rvalid_all;
  logic [ADDR_W-1:0]              ram_addr;
  logic [DATA_W-1:0]              ram_wdata;
  logic [DATA_W-1:0]              ram_rdata;
  logic                           ram_we, ram_re;

  // ---- unify both sides into one requester list
  assign req_all = {cop_wr_req, cop_rd_req, cpu_req};

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu_unpack
    assign addr_all[g]  = cpu_addr[g*ADDR_W +: ADDR_W];
    assign wdata_all[g] = cpu_wdata[g*DATA_W +: DATA_W];
  end
  assign addr_all[IDX_COP_RD]  = cop_rd_addr;
  assign wdata_all[IDX_COP_RD] = '0;
  assign addr_all[IDX_COP_WR]  = cop_wr_addr;
  assign wdata_all[IDX_COP_WR] = cop_wdata;

  // ---- mode decode and fixed-priority pick
  sram_arb_decode i_decode (
    .cfg_map_cop (cfg_map_cop),
    .cfg_host_en (cfg_host_en),
    .pos         (pos),
    .legal       (legal)
  );

  assign elig = req_all & legal;

  sram_arb_pick #(.N(NREQ), .POS_W(POS_W)) i_pick (
    .elig  (elig),
    .pos   (pos),
    .grant (grant)
  );

  assign stall_all = elig & ~grant;

  // ---- RAM port steering (grant is one-hot or empty)
  always_comb begin
    ram_addr  = '0;
    ram_wdata = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (grant[i]) begin
        ram_addr  = addr_all[i];
        ram_wdata = wdata_all[i];
      end
    end
  end

  assign ram_we = |(grant & WR_MASK);
  assign ram_re = |(grant & RD_MASK);

  sram_arb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  // ---- response tracking: next state and registers
  always_comb begin
    rsp_ram_d  = grant & RD_MASK;
    rsp_zero_d = req_all & ~legal & RD_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ram_q  <= '0;
      rsp_zero_q <= '0;
    end else begin
      rsp_ram_q  <= rsp_ram_d;
      rsp_zero_q <= rsp_zero_d;
    end
  end

  assign rvalid_all = rsp_ram_q | rsp_zero_q;

  // ---- outputs
  for (genvar g = 0; g < NCPU; g++) begin : g_cpu_out
    assign cpu_rdata[g*DATA_W +: DATA_W] = rsp_ram_q[g] ? ram_rdata : '0;
  end
  assign cpu_stall    = stall_all[NCPU-1:0];
  assign cpu_rvalid   = rvalid_all[NCPU-1:0];
  assign cop_rd_stall = stall_all[IDX_COP_RD];
  assign cop_wr_stall = stall_all[IDX_COP_WR];
  assign cop_rvalid   = rvalid_all[IDX_COP_RD];
  assign cop_rdata    = rsp_ram_q[IDX_COP_RD] ? ram_rdata : '0;

  // ---- assertions
  // R10
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req_all) == '0));

  // R1
  host_write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_map_cop && |(cpu_req & WR_MASK[NCPU-1:0])) |-> ((grant & RD_MASK) == '0));

  // R2
  cop_write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_map_cop && cop_wr_req) |-> grant[IDX_COP_WR]);

  // R3
  dbg_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_map_cop && !cfg_host_en) |-> (grant[IDX_DWR:IDX_FETCH] == '0));

  // R5
  shr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_map_cop |-> (grant[IDX_PWR:IDX_FETCH] == '0));

  // R6
  host_cop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_map_cop |-> (!grant[IDX_COP_RD] && !grant[IDX_COP_WR]));

  for (genvar g = 0; g < NREQ; g++) begin : g_chk
    if (RD_MASK[g]) begin : g_rd
      // R7
      gated_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_all[g] && !legal[g]) |=> (rvalid_all[g] && !rsp_ram_q[g]));
      // R9
      rvalid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_all[g] |-> $past(req_all[g]));
    end else begin : g_wr
      // R9
      no_write_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_all[g]);
    end
    // R8
    stall_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_all[g] |-> (|grant && !grant[g]));
  end

endmodule

// File: tb/test_shared_ram_arbiter.sv
module test_shared_ram_arbiter;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NP = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n;
  logic            cfg_map, cfg_en;
  logic [NP-1:0]   rq;
  logic [AW-1:0]   adr [NP];
  logic [DW-1:0]   wd  [NP];

  logic [7*AW-1:0] cpu_addr_p;
  logic [7*DW-1:0] cpu_wdata_p;
  logic [6:0]      cpu_stall, cpu_rvalid;
  logic [7*DW-1:0] cpu_rdata;
  logic            cop_rd_stall, cop_wr_stall, cop_rvalid;
  logic [DW-1:0]   cop_rdata;

  always_comb begin
    for (int i = 0; i < 7; i++) begin
      cpu_addr_p[i*AW +: AW]  = adr[i];
      cpu_wdata_p[i*DW +: DW] = wd[i];
    end
  end

  shared_ram_arbiter #(.ADDR_W(AW), .DATA_W(DW)) i_shared_ram_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_map_cop(cfg_map), .cfg_host_en(cfg_en),
    .cpu_req(rq[6:0]), .cpu_addr(cpu_addr_p), .cpu_wdata(cpu_wdata_p),
    .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .cop_rd_req(rq[7]), .cop_rd_addr(adr[7]),
    .cop_wr_req(rq[8]), .cop_wr_addr(adr[8]), .cop_wdata(wd[8]),
    .cop_rd_stall(cop_rd_stall), .cop_wr_stall(cop_wr_stall),
    .cop_rvalid(cop_rvalid), .cop_rdata(cop_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [DW-1:0] mem_m [1<<AW];

  typedef struct {
    int            port;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;
  exp_t sb [$];

  // priority lists from the requirements, strongest first; -1 ends a list
  function automatic int plist(int md, int k);
    int h [9] = '{6, 4, 2, 5, 3, 0, 1, -1, -1};
    int d [9] = '{8, 6, 5, 7, -1, -1, -1, -1, -1};
    int s [9] = '{8, 6, 4, 5, 3, 7, -1, -1, -1};
    case (md)
      0:       return h[k];
      1:       return d[k];
      default: return s[k];
    endcase
  endfunction

  function automatic int cur_mode();
    return cfg_map ? (cfg_en ? 2 : 1) : 0;
  endfunction

  function automatic bit is_legal(int p);
    for (int k = 0; k < NP; k++) if (plist(cur_mode(), k) == p) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit is_rd(int p);
    return (p == 0 || p == 1 || p == 3 || p == 5 || p == 7);
  endfunction

  function automatic int winner();
    for (int k = 0; k < NP; k++) begin
      if (plist(cur_mode(), k) >= 0 && rq[plist(cur_mode(), k)]) return plist(cur_mode(), k);
    end
    return -1;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // one arbitration cycle: called right after a falling edge with inputs set
  task automatic step(string tag, output int w);
    logic [NP-1:0] exp_stall;
    logic [NP-1:0] act_stall;
    exp_t e;
    #1;
    w = winner();
    exp_stall = '0;
    for (int p = 0; p < NP; p++)
      if (rq[p] && is_legal(p) && p != w) exp_stall[p] = 1'b1;
    act_stall = {cop_wr_stall, cop_rd_stall, cpu_stall};
    check(act_stall == exp_stall, tag, "stall vector", act_stall, exp_stall);
    for (int p = 0; p < 8; p++) begin
      if (rq[p] && is_rd(p)) begin
        if (p == w) begin
          e.port = p; e.data = mem_m[adr[p]]; e.tag = tag; sb.push_back(e);
        end else if (!is_legal(p)) begin
          e.port = p; e.data = '0; e.tag = tag; sb.push_back(e);
        end
      end
    end
    @(posedge clk);
    if (w >= 0 && !is_rd(w)) mem_m[adr[w]] = wd[w];
    @(negedge clk);
  endtask

  // retire granted and gated requests; stalled ones stay stable
  task automatic retire(int w);
    for (int p = 0; p < NP; p++) if (rq[p] && !is_legal(p)) rq[p] = 1'b0;
    if (w >= 0) rq[w] = 1'b0;
  endtask

  task automatic drain(string tag);
    int w;
    while (rq != '0) begin
      step(tag, w);
      retire(w);
    end
    @(negedge clk);
  endtask

  task automatic set_req(int p, int a, logic [DW-1:0] d);
    rq[p] = 1'b1; adr[p] = a[AW-1:0]; wd[p] = d;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < 8; p++) begin
        logic          v;
        logic [DW-1:0] d;
        exp_t          e;
        v = (p < 7) ? cpu_rvalid[p] : cop_rvalid;
        d = (p < 7) ? cpu_rdata[p*DW +: DW] : cop_rdata;
        if (v) begin
          if (sb.size() == 0) begin
            check(1'b0, "R9", $sformatf("unexpected rvalid port %0d", p), d, 0);
          end else begin
            e = sb.pop_front();
            check(e.port == p, e.tag, "response port", p, e.port);
            check(d == e.data, e.tag, $sformatf("read data port %0d", p), d, e.data);
          end
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    rst_n = 1'b0; cfg_map = 1'b0; cfg_en = 1'b0; rq = '1;
    for (int p = 0; p < NP; p++) begin adr[p] = '0; wd[p] = '0; end
    repeat (3) @(negedge clk);
    // R11: no read-valid while held in reset, even with requests present
    check({cop_rvalid, cpu_rvalid} == '0, "R11", "rvalid in reset", {cop_rvalid, cpu_rvalid}, 0);
    rq = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({cop_rvalid, cpu_rvalid} == '0, "R11", "rvalid after reset", {cop_rvalid, cpu_rvalid}, 0);

    // R10: fill every word through host data writes, then read back
    for (int a = 0; a < (1 << AW); a++) begin
      set_req(4, a, 16'h5a0f ^ (16'h1111 * a[DW-1:0]));
      step("R10", w); retire(w);
    end
    for (int a = 0; a < (1 << AW); a++) begin
      set_req(3, a, '0);
      step("R9", w); retire(w);
    end
    // R10: write then immediate read of the same word
    set_req(6, 9, 16'hbeef); step("R10", w); retire(w);
    set_req(5, 9, '0);       step("R10", w); retire(w);
    @(negedge clk);

    // R1: all host classes and both coprocessor classes at once
    for (int p = 0; p < NP; p++) set_req(p, p + 2, 16'h0100 + p[DW-1:0]);
    drain("R1");
    // R1: reads and fetches only, fetch beats program read
    set_req(0, 1, '0); set_req(1, 2, '0); set_req(3, 4, '0); set_req(5, 5, '0);
    drain("R1");

    // R6: coprocessor write dropped, coprocessor read answers zero
    set_req(8, 3, 16'hdead); set_req(7, 7, '0);
    drain("R6");
    set_req(3, 3, '0);
    drain("R6");

    // R2: debug-only coprocessor mode, everything requested
    cfg_map = 1'b1; cfg_en = 1'b0;
    @(negedge clk);
    for (int p = 0; p < NP; p++) set_req(p, 15 - p, 16'h0200 + p[DW-1:0]);
    drain("R2");
    // R3: host data/program writes dropped, non-debug reads answer zero
    set_req(4, 5, 16'hcafe); set_req(2, 6, 16'hf00d);
    set_req(0, 5, '0); set_req(1, 5, '0); set_req(3, 5, '0);
    drain("R3");
    set_req(5, 5, '0); set_req(7, 6, '0);
    drain("R3");

    // R4: shared coprocessor mode, everything requested
    cfg_en = 1'b1;
    @(negedge clk);
    for (int p = 0; p < NP; p++) set_req(p, p, 16'h0300 + p[DW-1:0]);
    drain("R4");
    set_req(4, 10, 16'h7777); set_req(3, 11, '0); set_req(7, 12, '0);
    drain("R4");
    set_req(3, 10, '0);
    drain("R4");
    // R5: fetch and program read zero, program write dropped
    set_req(2, 13, 16'h1234); set_req(0, 13, '0); set_req(1, 13, '0);
    drain("R5");
    set_req(5, 13, '0);
    drain("R5");

    // R7/R8: random traffic per mode, stalled requests held stable
    for (int md = 0; md < 3; md++) begin
      cfg_map = (md != 0);
      cfg_en  = (md == 2);
      @(negedge clk);
      for (int c = 0; c < 1500; c++) begin
        for (int p = 0; p < NP; p++)
          if (!rq[p] && $urandom_range(2) == 0)
            set_req(p, int'($urandom_range((1 << AW) - 1)), DW'($urandom));
        step("R8", w);
        retire(w);
      end
      drain("R7");
    end

    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R9", "responses outstanding", sb.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule